// File: doc/BRIEF.md
# Indirect PCI Configuration and I/O-Port Access Port

This block sits on a host register bus and lets software reach PCI configuration space and PCI I/O-port space through a small set of registers. Software first writes a target address into a latch register. It then reads or writes one of two data windows. One window produces a configuration cycle and the other produces an I/O-port cycle. Each data-window access sends exactly one request to a downstream bus-master model. The host access is held off, with its ready signal low, until that request completes.

The host gives a byte address and a transfer size. The low two address bits inside a window choose the byte lane, or the halfword lane for halfword accesses. The block turns these into the 4-bit byte enables that go downstream. Write data moves up into the addressed lane. Read data moves down so that the addressed bytes land in the low bits.

If a request uses a different cycle type from the previous one, the block holds the request back for one extra cycle. This way a configuration cycle never starts on the heels of an I/O cycle, or the reverse.

Top module: `cfg_access_port`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the following hold: `h_ready` is 0, `d_req` is 0, the address latch reads 0, and the recorded previous cycle type is configuration.
- R2: The address latch sits at byte offset 0x064. A write updates only the bytes selected by the lane logic (see R5), and a later read returns the latch content through the same lane logic. The access completes with `h_ready` one clock after it is accepted and raises no downstream request.
- R3: An access to the configuration window (0x068 to 0x06B) raises exactly one request with `d_type`=0. Its `d_addr` is the latch value limited to bits 23:2, with bits 1:0 and bits above 23 forced to zero. Inside that address, bus is bits 23:16, device/function is bits 15:8, and the register is bits 7:2.
- R4: An access to the I/O window (0x06C to 0x06F) raises exactly one request with `d_type`=1. Its `d_addr` is the low 16 bits of the latch (the full port number), with the upper bits zero.
- R5: `h_size` is 0 for a byte, 1 for a halfword and 2 for a word. A byte access sets enable bit `h_addr[1:0]`. A halfword access sets 0011 when `h_addr[1]`=0 and 1100 when `h_addr[1]`=1. A word access sets 1111.
- R6: `d_wr` equals `h_wr`. `d_wdata` is `h_wdata` shifted up by 8 times the lane index, where the lane index is `h_addr[1:0]` for bytes, `{h_addr[1],0}` for halfwords, and 0 for words.
- R7: On a window read, `h_rdata` is `d_rdata` shifted down by the lane index and then zero-extended to the transfer size. A window write returns 0.
- R8: `h_ready` stays low while a request is outstanding. It rises for exactly one cycle, on the clock after the edge that samples `d_ack`, and `d_req` drops on that same edge.
- R9: An access to any other offset completes one clock later with read data 0. It raises no request and leaves the address latch unchanged.
- R10: A window access whose cycle type matches the previous request raises `d_req` one clock after acceptance. A type change raises it two clocks after acceptance.
- R11: While `d_req` is high and `d_ack` is low, `d_type`, `d_wr`, `d_be`, `d_addr` and `d_wdata` hold steady.
- R12: A reset while a request is outstanding drops `d_req` at that edge, and no response is returned for the aborted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access request, held until `h_ready` |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | AW | Host byte address |
| h_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| h_wdata | input | DW | Host write data, low-aligned |
| h_rdata | output | DW | Host read data, low-aligned |
| h_ready | output | 1 | One-cycle completion pulse |
| d_req | output | 1 | Downstream request, held until `d_ack` |
| d_type | output | 1 | 0 configuration cycle, 1 I/O-port cycle |
| d_wr | output | 1 | Downstream direction, 1 is write |
| d_be | output | DW/8 | Downstream byte enables |
| d_addr | output | DW | Downstream target address |
| d_wdata | output | DW | Downstream write data in lane position |
| d_rdata | input | DW | Downstream read data, valid with `d_ack` |
| d_ack | input | 1 | Downstream completion |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- request fields stay stable until the acknowledge arrives;
- the request drops, and the single-cycle ready pulse follows, right after the acknowledge;
- the byte-enable shape is always legal;
- ready and an outstanding request never overlap.

The directed scenarios cover what only chosen stimulus can show:
- the packing of configuration and port addresses;
- lane selection for every size and offset;
- the zero-extension of read data;
- the extra turnaround cycle on a change of cycle type;
- that undefined offsets leave the latch untouched;
- that a reset mid-request both aborts the request and restores the configuration type as the previous type.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic {
    CYC_CFG = 1'b0,
    CYC_IO  = 1'b1
  } cyc_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_WAIT,
    ST_RESP
  } seq_state_e;
endpackage

// File: rtl/cap_decode.sv
module cap_decode #(
  parameter int AW       = 12,
  parameter int ADDR_OFF = 'h064,
  parameter int CFG_OFF  = 'h068,
  parameter int IO_OFF   = 'h06C
) (
  input  logic [AW-1:0] h_addr,
  output logic          hit_addr,
  output logic          hit_cfg,
  output logic          hit_io
);
  localparam logic [AW-1:0] A_OFF = AW'(ADDR_OFF);
  localparam logic [AW-1:0] C_OFF = AW'(CFG_OFF);
  localparam logic [AW-1:0] I_OFF = AW'(IO_OFF);

  // Word-granular decode; the low two bits only steer lanes.
  always_comb begin
    hit_addr = (h_addr[AW-1:2] == A_OFF[AW-1:2]);
    hit_cfg  = (h_addr[AW-1:2] == C_OFF[AW-1:2]);
    hit_io   = (h_addr[AW-1:2] == I_OFF[AW-1:2]);
  end

  // R9: the three targets never overlap
  always_comb begin
    decode_onehot_chk: assert ($countones({hit_addr, hit_cfg, hit_io}) <= 1);
  end
endmodule

// File: rtl/cap_lane.sv
module cap_lane
  import cap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]      off,
  input  logic [1:0]      size,
  input  logic [DW-1:0]   wdata_in,
  input  logic [DW-1:0]   rd_src,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   wdata_lane,
  output logic [DW-1:0]   rdata_low
);
  localparam int NB = DW / 8;
  localparam logic [DW-1:0] MASK_B = DW'(8'hFF);
  localparam logic [DW-1:0] MASK_H = DW'(16'hFFFF);

  logic [1:0]      lane;
  logic [4:0]      shamt;
  logic [DW-1:0]   mask;

  always_comb begin
    unique case (xfer_size_e'(size))
      SZ_BYTE: begin
        lane = off;
        be   = NB'(1) << lane;
        mask = MASK_B;
      end
      SZ_HALF: begin
        lane = {off[1], 1'b0};
        be   = NB'(3) << lane;
        mask = MASK_H;
      end
      default: begin
        lane = 2'd0;
        be   = {NB{1'b1}};
        mask = {DW{1'b1}};
      end
    endcase
    shamt      = {lane, 3'b000};
    wdata_lane = wdata_in << shamt;
    rdata_low  = (rd_src >> shamt) & mask;
  end
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int DW      = 32,
  parameter int CFG_AW  = 24,
  parameter int PORT_AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_req,
  input  logic            h_wr,
  input  logic            hit_addr,
  input  logic            hit_cfg,
  input  logic            hit_io,
  input  logic [DW/8-1:0] lane_be,
  input  logic [DW-1:0]   lane_wdata,
  input  logic [DW-1:0]   lane_rdata,
  output logic [DW-1:0]   rd_src,
  output logic            h_ready,
  output logic [DW-1:0]   h_rdata,
  output logic            d_req,
  output logic            d_type,
  output logic            d_wr,
  output logic [DW/8-1:0] d_be,
  output logic [DW-1:0]   d_addr,
  output logic [DW-1:0]   d_wdata,
  input  logic [DW-1:0]   d_rdata,
  input  logic            d_ack
);
  localparam int NB = DW / 8;
  localparam logic [DW-1:0] CFG_MASK  = ((DW'(1) << CFG_AW) - DW'(1)) & ~DW'(3);
  localparam logic [DW-1:0] PORT_MASK = (DW'(1) << PORT_AW) - DW'(1);

  seq_state_e      state;
  cyc_type_e       last_type;
  cyc_type_e       typ_q;
  cyc_type_e       new_type;
  logic [DW-1:0]   addr_reg;
  logic            win_hit;

  assign win_hit  = hit_cfg | hit_io;
  assign new_type = hit_io ? CYC_IO : CYC_CFG;
  assign rd_src   = (state == ST_WAIT) ? d_rdata : addr_reg;
  assign d_type   = (typ_q == CYC_IO);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      last_type <= CYC_CFG;
      typ_q     <= CYC_CFG;
      addr_reg  <= '0;
      d_req     <= 1'b0;
      d_wr      <= 1'b0;
      d_be      <= '0;
      d_addr    <= '0;
      d_wdata   <= '0;
      h_ready   <= 1'b0;
      h_rdata   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (h_req) begin
            if (win_hit) begin
              typ_q     <= new_type;
              last_type <= new_type;
              d_wr      <= h_wr;
              d_be      <= lane_be;
              d_wdata   <= lane_wdata;
              d_addr    <= hit_io ? (addr_reg & PORT_MASK) : (addr_reg & CFG_MASK);
              if (new_type != last_type) begin
                state <= ST_TURN;
              end else begin
                d_req <= 1'b1;
                state <= ST_WAIT;
              end
            end else begin
              if (hit_addr && h_wr) begin
                for (int i = 0; i < NB; i++) begin
                  if (lane_be[i]) addr_reg[8*i +: 8] <= lane_wdata[8*i +: 8];
                end
              end
              h_rdata <= (hit_addr && !h_wr) ? lane_rdata : '0;
              h_ready <= 1'b1;
              state   <= ST_RESP;
            end
          end
        end
        ST_TURN: begin
          d_req <= 1'b1;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (d_ack) begin
            d_req   <= 1'b0;
            h_ready <= 1'b1;
            h_rdata <= d_wr ? '0 : lane_rdata;
            state   <= ST_RESP;
          end
        end
        default: begin
          h_ready <= 1'b0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    d_req && !d_ack |=> d_req && $stable(d_addr) && $stable(d_be) && $stable(d_type)
                        && $stable(d_wr) && $stable(d_wdata));

  // R8
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    d_req && d_ack |=> h_ready && !d_req);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    h_ready |=> !h_ready);

  // R8
  no_ready_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(h_ready && d_req));

  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    d_req |-> ($countones(d_be) == 1 || $countones(d_be) == 2 || $countones(d_be) == NB));
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port #(
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int CFG_AW   = 24,
  parameter int PORT_AW  = 16,
  parameter int ADDR_OFF = 'h064,
  parameter int CFG_OFF  = 'h068,
  parameter int IO_OFF   = 'h06C
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_req,
  input  logic            h_wr,
  input  logic [AW-1:0]   h_addr,
  input  logic [1:0]      h_size,
  input  logic [DW-1:0]   h_wdata,
  output logic [DW-1:0]   h_rdata,
  output logic            h_ready,
  output logic            d_req,
  output logic            d_type,
  output logic            d_wr,
  output logic [DW/8-1:0] d_be,
  output logic [DW-1:0]   d_addr,
  output logic [DW-1:0]   d_wdata,
  input  logic [DW-1:0]   d_rdata,
  input  logic            d_ack
);
  logic            hit_addr, hit_cfg, hit_io;
  logic [DW/8-1:0] lane_be;
  logic [DW-1:0]   lane_wdata, lane_rdata, rd_src;

  cap_decode #(
    .AW(AW), .ADDR_OFF(ADDR_OFF), .CFG_OFF(CFG_OFF), .IO_OFF(IO_OFF)
  ) u_decode (
    .h_addr(h_addr), .hit_addr(hit_addr), .hit_cfg(hit_cfg), .hit_io(hit_io)
  );

  cap_lane #(.DW(DW)) u_lane (
    .off(h_addr[1:0]), .size(h_size), .wdata_in(h_wdata), .rd_src(rd_src),
    .be(lane_be), .wdata_lane(lane_wdata), .rdata_low(lane_rdata)
  );

  cap_seq #(.DW(DW), .CFG_AW(CFG_AW), .PORT_AW(PORT_AW)) u_seq (
    .clk(clk), .rst(rst), .h_req(h_req), .h_wr(h_wr),
    .hit_addr(hit_addr), .hit_cfg(hit_cfg), .hit_io(hit_io),
    .lane_be(lane_be), .lane_wdata(lane_wdata), .lane_rdata(lane_rdata),
    .rd_src(rd_src), .h_ready(h_ready), .h_rdata(h_rdata),
    .d_req(d_req), .d_type(d_type), .d_wr(d_wr), .d_be(d_be),
    .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata), .d_ack(d_ack)
  );
endmodule

// File: tb/tb_cfg_access_port.sv
module tb_cfg_access_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_req = 1'b0;
  logic        h_wr = 1'b0;
  logic [11:0] h_addr = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_ready;
  logic        d_req, d_type, d_wr;
  logic [3:0]  d_be;
  logic [31:0] d_addr, d_wdata;
  logic [31:0] d_rdata = '0;
  logic        d_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // downstream model state
  int          m_lat = 0;
  int          m_cnt = 0;
  bit          m_en  = 1'b1;
  int          nreq  = 0;
  logic        m_type, m_wr;
  logic [3:0]  m_be;
  logic [31:0] m_addr, m_wdata;

  // results of the last host access
  logic [31:0] r_data;
  int          r_dreq_at, r_ready_at, r_nreq;

  cfg_access_port dut (
    .clk(clk), .rst(rst), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
    .d_req(d_req), .d_type(d_type), .d_wr(d_wr), .d_be(d_be), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rdata), .d_ack(d_ack)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      d_ack = 1'b0;
      m_cnt = 0;
    end else if (d_ack) begin
      d_ack = 1'b0;
    end else if (d_req && m_en) begin
      if (m_cnt == m_lat) begin
        d_ack   = 1'b1;
        m_cnt   = 0;
        nreq++;
        m_type  = d_type;
        m_wr    = d_wr;
        m_be    = d_be;
        m_addr  = d_addr;
        m_wdata = d_wdata;
      end else begin
        m_cnt++;
      end
    end else begin
      m_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [11:0] addr, input logic [1:0] size,
                        input logic [31:0] wdata);
    int n = 0;
    int start = nreq;
    r_dreq_at = 0;
    @(negedge clk);
    h_req = 1'b1; h_wr = wr; h_addr = addr; h_size = size; h_wdata = wdata;
    forever begin
      @(negedge clk);
      n++;
      if (d_req && r_dreq_at == 0) r_dreq_at = n;
      if (h_ready) break;
      if (n > 1000) begin
        chk("R8 ready timeout", 32'(n), 32'd0);
        break;
      end
    end
    r_ready_at = n;
    r_data = h_rdata;
    r_nreq = nreq - start;
    h_req = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 h_ready after reset", 32'(h_ready), 32'd0);
    chk("R1 d_req after reset", 32'(d_req), 32'd0);
    rst = 1'b0;
    access(0, 12'h064, 2'd2, '0);
    chk("R1 latch reads zero", r_data, 32'h0);
  endtask

  task automatic t_addr_reg;
    access(1, 12'h064, 2'd2, 32'h0012_3A0C);
    chk("R2 latch write completes in one clock", 32'(r_ready_at), 32'd1);
    chk("R2 latch write raises no request", 32'(r_nreq), 32'd0);
    access(0, 12'h064, 2'd2, '0);
    chk("R2 latch word readback", r_data, 32'h0012_3A0C);
    access(1, 12'h066, 2'd0, 32'h0000_0055);
    access(0, 12'h064, 2'd2, '0);
    chk("R2 latch byte lane write", r_data, 32'h0055_3A0C);
    access(0, 12'h066, 2'd1, '0);
    chk("R2 latch halfword read", r_data, 32'h0000_0055);
  endtask

  task automatic t_cfg;
    access(1, 12'h064, 2'd2, 32'hFF05_283F);
    d_rdata = 32'hA1B2_C3D4;
    access(0, 12'h069, 2'd0, '0);
    chk("R3 one config request", 32'(r_nreq), 32'd1);
    chk("R3 config type", 32'(m_type), 32'd0);
    chk("R3 config address packing", m_addr, 32'h0005_283C);
    chk("R5 byte lane 1 enable", 32'(m_be), 32'h2);
    chk("R7 byte read shifted down", r_data, 32'h0000_00C3);
    chk("R10 same type request delay", 32'(r_dreq_at), 32'd1);
    chk("R8 ready one clock after ack", 32'(r_ready_at), 32'd2);
    access(1, 12'h06A, 2'd1, 32'h0000_BEEF);
    chk("R5 upper halfword enables", 32'(m_be), 32'hC);
    chk("R6 write direction", 32'(m_wr), 32'd1);
    chk("R6 halfword write lane shift", m_wdata, 32'hBEEF_0000);
    chk("R7 write returns zero", r_data, 32'h0);
    access(0, 12'h068, 2'd2, '0);
    chk("R5 word enables", 32'(m_be), 32'hF);
    chk("R7 word read", r_data, 32'hA1B2_C3D4);
    access(0, 12'h06B, 2'd1, '0);
    chk("R5 misaligned halfword uses upper lane", 32'(m_be), 32'hC);
    chk("R7 halfword read zero-extended", r_data, 32'h0000_A1B2);
  endtask

  task automatic t_io;
    access(1, 12'h064, 2'd2, 32'hABCD_03F9);
    d_rdata = 32'h1122_3344;
    access(0, 12'h06D, 2'd0, '0);
    chk("R4 one io request", 32'(r_nreq), 32'd1);
    chk("R4 io type", 32'(m_type), 32'd1);
    chk("R4 io port address", m_addr, 32'h0000_03F9);
    chk("R10 type change adds a cycle", 32'(r_dreq_at), 32'd2);
    chk("R7 io byte read", r_data, 32'h0000_0033);
    access(1, 12'h06C, 2'd0, 32'h0000_007E);
    chk("R10 repeated io type no gap", 32'(r_dreq_at), 32'd1);
    chk("R6 byte write lane 0", m_wdata, 32'h0000_007E);
    chk("R5 byte lane 0 enable", 32'(m_be), 32'h1);
    access(0, 12'h068, 2'd2, '0);
    chk("R10 back to config adds a cycle", 32'(r_dreq_at), 32'd2);
    chk("R3 config type after io", 32'(m_type), 32'd0);
  endtask

  task automatic t_undef;
    access(1, 12'h070, 2'd2, 32'hDEAD_BEEF);
    chk("R9 undefined write no request", 32'(r_nreq), 32'd0);
    chk("R9 undefined write completes", 32'(r_ready_at), 32'd1);
    access(0, 12'h064, 2'd2, '0);
    chk("R9 latch unchanged", r_data, 32'hABCD_03F9);
    access(0, 12'h060, 2'd2, '0);
    chk("R9 undefined read zero", r_data, 32'h0);
  endtask

  task automatic t_latency;
    m_lat = 5;
    access(0, 12'h068, 2'd2, '0);
    chk("R8 ready waits for slow ack", 32'(r_ready_at), 32'd7);
    chk("R11 one request under latency", 32'(r_nreq), 32'd1);
    m_lat = 0;
  endtask

  task automatic t_abort;
    m_en = 1'b0;
    @(negedge clk);
    h_req = 1'b1; h_wr = 1'b0; h_addr = 12'h06C; h_size = 2'd2;
    repeat (3) @(negedge clk);
    chk("R12 request outstanding before reset", 32'(d_req), 32'd1);
    rst = 1'b1; h_req = 1'b0;
    @(negedge clk);
    chk("R12 request dropped by reset", 32'(d_req), 32'd0);
    chk("R12 no response on abort", 32'(h_ready), 32'd0);
    rst = 1'b0;
    m_en = 1'b1;
    access(0, 12'h068, 2'd2, '0);
    chk("R1 previous type is config after reset", 32'(r_dreq_at), 32'd1);
  endtask

  initial begin
    t_reset();
    t_addr_reg();
    t_cfg();
    t_io();
    t_undef();
    t_latency();
    t_abort();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule